// File: doc/BRIEF.md
# Receive Checksum Reject Policy

This block decides, once per received packet, whether the packet is kept or thrown away because a header checksum failed. Upstream logic parses the packet and computes the checksums. At end of packet it presents one strobe together with two small vectors. The first says which of the IP, TCP and UDP headers were found. The second says which of those checksums did not match. The block combines these flags with a four-bit policy register. That register holds one master validation switch and one reject switch for each protocol. The master switch gates all three reject switches.

One cycle after the strobe, the block gives a single-cycle verdict. The verdict carries a reject bit, a per-protocol cause vector and per-protocol status bits, which are attached to the packet descriptor. The status bits report every checksum error that validation finds, even when the reject switch for that protocol is off. The strobe path has no back-pressure, so the block accepts a packet flag set on every cycle, including back-to-back packets. The verdict is a one-cycle pulse that the consumer must capture when it appears; no ready signal exists. The policy register clears on the asynchronous hard reset and on a synchronous soft reset.

Top module: `rx_csum_verdict`

## Requirements
- R1: After the asynchronous hard reset (rst_n low), the policy register reads 0 on pol_rdata.
- R2: A cycle with soft_rst high clears the policy register to 0 at the next clock edge. soft_rst takes priority over a write in the same cycle.
- R3: A cycle with eop_valid high makes vrd_valid high for exactly the next cycle. Without eop_valid, vrd_valid is low in the next cycle.
- R4: Policy bit 0 is the master enable. While it is 0, no packet is rejected, and the seen and error status outputs are 0 whatever the other policy bits hold.
- R5: Protocol index 0 is IP, and policy bit 1 is its reject enable. With the master enable set, a packet with hdr_seen[0]=1 and csum_bad[0]=1 is rejected when bit 1 is set.
- R6: Protocol index 1 is TCP, and policy bit 2 is its reject enable. With the master enable set, a packet with hdr_seen[1]=1 and csum_bad[1]=1 is rejected when bit 2 is set.
- R7: Protocol index 2 is UDP, and policy bit 3 is its reject enable. With the master enable set, a packet with hdr_seen[2]=1 and csum_bad[2]=1 is rejected when bit 3 is set.
- R8: A csum_bad bit whose hdr_seen bit is 0 never contributes to rejection or to the error status.
- R9: With the master enable set, vrd_seen equals hdr_seen and vrd_err equals hdr_seen AND csum_bad, independent of the three reject enables.
- R10: vrd_cause bit i is set exactly when protocol i caused rejection, and vrd_reject is the OR of vrd_cause.
- R11: The verdict uses the policy value held before any write in the strobe cycle. A write in that cycle affects only later packets.
- R12: While vrd_valid is low, vrd_reject, vrd_cause, vrd_seen and vrd_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset of the policy register |
| pol_wr | input | 1 | Policy register write strobe |
| pol_wdata | input | 4 | Policy write data: bit0 master, bit1 IP, bit2 TCP, bit3 UDP reject |
| pol_rdata | output | 4 | Current policy register value |
| eop_valid | input | 1 | End-of-packet strobe qualifying the flags |
| hdr_seen | input | 3 | Header found: bit0 IP, bit1 TCP, bit2 UDP |
| csum_bad | input | 3 | Checksum mismatch, same bit order |
| vrd_valid | output | 1 | Verdict pulse, one cycle after eop_valid |
| vrd_reject | output | 1 | Packet is to be discarded |
| vrd_cause | output | 3 | Protocols that caused rejection |
| vrd_seen | output | 3 | Headers reported as validated |
| vrd_err | output | 3 | Checksum errors reported |

## Verification
Every combination of the 16 policy values, 8 header-present vectors and 8 checksum-error vectors is sent as a packet. This sweep separates the master gate from the per-protocol enables, and it separates errors on absent headers from errors on present ones. Back-to-back strobes and idle gaps check the single-cycle verdict timing. A policy write in the same cycle as a strobe shows whether the old or the new policy governs that packet. Soft reset is applied alone and together with a write, which confirms that the clear wins.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
  localparam int unsigned NPROTO = 3;
  localparam int unsigned POL_W  = NPROTO + 1;
  localparam int unsigned MASTER_BIT = 0;

  typedef logic [NPROTO-1:0] proto_vec_t;
  typedef logic [POL_W-1:0]  pol_t;

  typedef struct packed {
    logic       reject;
    proto_vec_t cause;
    proto_vec_t seen;
    proto_vec_t err;
  } verdict_t;
endpackage

// File: rtl/rxcs_policy_reg.sv
module rxcs_policy_reg
  import rxcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wr,
  input  pol_t wdata,
  output pol_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_rst) q <= '0;
    else if (wr)       q <= wdata;
  end

  assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (q == '0));
  assert_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !soft_rst) |=> (q == $past(wdata)));
endmodule

// File: rtl/rxcs_proto_eval.sv
module rxcs_proto_eval
  import rxcs_pkg::*;
(
  input  pol_t       pol,
  input  proto_vec_t hdr_seen,
  input  proto_vec_t csum_bad,
  output verdict_t   v
);
  logic master;
  assign master = pol[MASTER_BIT];

  for (genvar i = 0; i < NPROTO; i++) begin : g_proto
    logic seen_i, err_i;
    assign seen_i     = master & hdr_seen[i];
    assign err_i      = seen_i & csum_bad[i];
    assign v.seen[i]  = seen_i;
    assign v.err[i]   = err_i;
    assign v.cause[i] = err_i & pol[i+1];
  end

  assign v.reject = |v.cause;

  always_comb begin
    assert_absent_R8: assert ((v.err & ~hdr_seen) == '0);
  end
endmodule

// File: rtl/rxcs_verdict_reg.sv
module rxcs_verdict_reg
  import rxcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     eop_valid,
  input  verdict_t d,
  output logic     valid,
  output verdict_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= eop_valid;
      q     <= eop_valid ? d : '0;
    end
  end

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eop_valid |=> valid);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_valid |=> !valid);
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (q == '0));
endmodule

// File: rtl/rx_csum_verdict.sv
module rx_csum_verdict
  import rxcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pol_wr,
  input  logic [POL_W-1:0]  pol_wdata,
  output logic [POL_W-1:0]  pol_rdata,
  input  logic              eop_valid,
  input  logic [NPROTO-1:0] hdr_seen,
  input  logic [NPROTO-1:0] csum_bad,
  output logic              vrd_valid,
  output logic              vrd_reject,
  output logic [NPROTO-1:0] vrd_cause,
  output logic [NPROTO-1:0] vrd_seen,
  output logic [NPROTO-1:0] vrd_err
);
  pol_t     pol;
  verdict_t v_d, v_q;

  rxcs_policy_reg u_pol (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr(pol_wr), .wdata(pol_wdata), .q(pol)
  );

  rxcs_proto_eval u_eval (
    .pol(pol), .hdr_seen(hdr_seen), .csum_bad(csum_bad), .v(v_d)
  );

  rxcs_verdict_reg u_vrd (
    .clk(clk), .rst_n(rst_n), .eop_valid(eop_valid), .d(v_d),
    .valid(vrd_valid), .q(v_q)
  );

  assign pol_rdata  = pol;
  assign vrd_reject = v_q.reject;
  assign vrd_cause  = v_q.cause;
  assign vrd_seen   = v_q.seen;
  assign vrd_err    = v_q.err;

  assert_master_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && !pol[MASTER_BIT]) |=> (!vrd_reject && vrd_seen == '0 && vrd_err == '0));
  assert_cause_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |-> (vrd_reject == (vrd_cause != '0)));
  assert_cause_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |-> ((vrd_cause & ~vrd_err) == '0 && (vrd_err & ~vrd_seen) == '0));
endmodule

// File: tb/test_rx_csum_verdict.sv
`timescale 1ns/1ps
module test_rx_csum_verdict;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       pol_wr = 1'b0;
  logic [3:0] pol_wdata = '0;
  logic [3:0] pol_rdata;
  logic       eop_valid = 1'b0;
  logic [2:0] hdr_seen = '0, csum_bad = '0;
  logic       vrd_valid, vrd_reject;
  logic [2:0] vrd_cause, vrd_seen, vrd_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_csum_verdict i_rx_csum_verdict (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .pol_wr(pol_wr), .pol_wdata(pol_wdata), .pol_rdata(pol_rdata),
    .eop_valid(eop_valid), .hdr_seen(hdr_seen), .csum_bad(csum_bad),
    .vrd_valid(vrd_valid), .vrd_reject(vrd_reject), .vrd_cause(vrd_cause),
    .vrd_seen(vrd_seen), .vrd_err(vrd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [3:0] p, input logic [2:0] s, input logic [2:0] b);
    logic [2:0] ss, ee, cc;
    ss = p[0] ? s : 3'b000;
    ee = ss & b;
    cc = ee & p[3:1];
    return {cc, ss, ee, 3'b000};
  endfunction

  task automatic write_pol(input logic [3:0] p);
    @(negedge clk);
    pol_wr = 1'b1; pol_wdata = p;
    @(negedge clk);
    pol_wr = 1'b0;
  endtask

  task automatic check_verdict(input string req, input logic [3:0] p,
                               input logic [2:0] s, input logic [2:0] b);
    logic [11:0] m;
    m = model(p, s, b);
    chk({req, " valid"}, vrd_valid, 1);
    chk({req, " R10 reject"}, vrd_reject, (m[11:9] != 0));
    chk({req, " R10 cause"}, vrd_cause, m[11:9]);
    chk({req, " R9 seen"}, vrd_seen, m[8:6]);
    chk({req, " R9 err"}, vrd_err, m[5:3]);
  endtask

  task automatic check_idle(input string req);
    chk({req, " R3 valid low"}, vrd_valid, 0);
    chk({req, " R12 outputs zero"}, {vrd_reject, vrd_cause, vrd_seen, vrd_err}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 policy reset", pol_rdata, 0);
    check_idle("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 policy after release", pol_rdata, 0);

    // Exhaustive sweep: R4 R5 R6 R7 R8 R9 R10, back-to-back strobes (R3)
    for (int p = 0; p < 16; p++) begin
      write_pol(p[3:0]);
      chk("R11 policy readback", pol_rdata, p);
      for (int s = 0; s < 8; s++) begin
        for (int b = 0; b < 8; b++) begin
          eop_valid = 1'b1; hdr_seen = s[2:0]; csum_bad = b[2:0];
          @(negedge clk);
          check_verdict(p[0] ? "R5 R6 R7 R8" : "R4 master off", p[3:0], s[2:0], b[2:0]);
        end
      end
      eop_valid = 1'b0; hdr_seen = '0; csum_bad = '0;
      @(negedge clk);
      check_idle("R3 gap");
    end

    // Targeted per-protocol checks
    write_pol(4'b0011);
    eop_valid = 1'b1; hdr_seen = 3'b001; csum_bad = 3'b001;
    @(negedge clk); eop_valid = 1'b0;
    chk("R5 IP reject", vrd_reject, 1);
    write_pol(4'b0101);
    eop_valid = 1'b1; hdr_seen = 3'b010; csum_bad = 3'b010;
    @(negedge clk); eop_valid = 1'b0;
    chk("R6 TCP reject", vrd_reject, 1);
    write_pol(4'b1001);
    eop_valid = 1'b1; hdr_seen = 3'b100; csum_bad = 3'b100;
    @(negedge clk); eop_valid = 1'b0;
    chk("R7 UDP reject", vrd_reject, 1);
    eop_valid = 1'b1; hdr_seen = 3'b011; csum_bad = 3'b100;
    @(negedge clk); eop_valid = 1'b0;
    chk("R8 absent UDP header", vrd_reject, 0);
    chk("R8 absent UDP err status", vrd_err, 0);
    write_pol(4'b0001);
    eop_valid = 1'b1; hdr_seen = 3'b111; csum_bad = 3'b111;
    @(negedge clk); eop_valid = 1'b0;
    chk("R9 errors reported without reject", vrd_err, 3'b111);
    chk("R9 no reject", vrd_reject, 0);

    // R11: write in strobe cycle, old policy applies
    write_pol(4'b0000);
    eop_valid = 1'b1; hdr_seen = 3'b111; csum_bad = 3'b111;
    pol_wr = 1'b1; pol_wdata = 4'b1111;
    @(negedge clk);
    pol_wr = 1'b0;
    chk("R11 old policy used", vrd_reject, 0);
    @(negedge clk);
    eop_valid = 1'b0;
    chk("R11 new policy on next packet", vrd_reject, 1);
    chk("R11 cause on next packet", vrd_cause, 3'b111);
    @(negedge clk);
    check_idle("R12 after burst");

    // R2 soft reset, alone and against a write
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R2 soft reset clears", pol_rdata, 0);
    write_pol(4'b1011);
    soft_rst = 1'b1; pol_wr = 1'b1; pol_wdata = 4'b0111;
    @(negedge clk);
    soft_rst = 1'b0; pol_wr = 1'b0;
    chk("R2 soft reset beats write", pol_rdata, 0);
    eop_valid = 1'b1; hdr_seen = 3'b111; csum_bad = 3'b111;
    @(negedge clk); eop_valid = 1'b0;
    chk("R4 cleared policy no reject", vrd_reject, 0);
    chk("R4 cleared policy seen zero", vrd_seen, 0);

    // R1 hard reset mid-run
    write_pol(4'b1111);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 hard reset clears", pol_rdata, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule